// File: doc/BRIEF.md
# Input Flow-Control Violation Checker

This block sits at one input of a packet switch and polices each arriving packet against the flow-control grants that the switch recently issued to the outputs. Every output has two kinds of grant: an output-queue grant and a memory grant. For each output and each grant kind, the block keeps the number of packet cycles since the last grant of that kind. A packet is legal only if every output it targets has a recent enough grant. A unicast packet accepts either kind of grant. A multicast packet accepts only a memory grant.

When the check is enabled and a packet targets an output without a qualifying grant, the block asserts a drop indication in the same cycle. It also records the event in a sticky status bit and in a sticky per-output violation vector, and it raises an interrupt unless software has masked it. The recency window `n` is a programmable value. The host clears the sticky bits by writing ones.

Top module: `flow_violation_guard`

## Requirements
- R1: When `cfgEnable` is 0, `pktDrop` is never asserted, whatever the grant history.
- R2: A unicast packet (`pktMcast`=0) is accepted when each of its destination outputs has an output-queue grant or a memory grant whose age is less than `n`.
- R3: A multicast packet (`pktMcast`=1) is accepted only when every destination output has a memory-grant age less than `n`. Output-queue grants are ignored for multicast packets.
- R4: `pktDrop` = `pktValid` AND `cfgEnable` AND (at least one destination output lacks a qualifying grant). `pktAccept` is `pktValid` AND NOT `pktDrop`. Both are combinational in the packet's own cycle. A grant in that same cycle is not yet seen. A `pktDest` of all zeros is accepted.
- R5: Each grant age resets to its saturated value 2^WIN_W-1 (15 by default). A grant loads the age with 0, and this takes priority over a strobe in the same cycle. Each `cycleStrobe` increments the age, saturating at the maximum. A grant issued k strobes ago therefore has age k, capped at 15.
- R6: `statusViol` is reset to 0 and set on the clock edge that ends a dropped packet's cycle. It then stays at 1 until a cycle with `clrStatus`=1 and no new drop. When a set and a clear arrive together, the set wins.
- R7: `violPorts` is reset to 0. Bit i is set when a dropped packet targets output i and output i lacks a qualifying grant. Bit i is cleared only by `clrViol[i]`=1, and a set in the same cycle wins over that clear.
- R8: `irq` = `statusViol` AND NOT `intMask`.
- R9: `cfgWindow` = 0 behaves as a window of 1. Values 1 to 15 are used as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 1 | Enables policing |
| cfgWindow | input | WIN_W | Recency window n in packet cycles |
| intMask | input | 1 | Masks the violation interrupt |
| clrStatus | input | 1 | Write-one-to-clear for the status bit |
| clrViol | input | NUM_PORTS | Write-one-to-clear for each violation bit |
| cycleStrobe | input | 1 | One pulse per packet cycle |
| oqGrant | input | NUM_PORTS | Output-queue grant issued, one bit per output |
| memGrant | input | NUM_PORTS | Memory grant issued, one bit per output |
| pktValid | input | 1 | A packet header is present this cycle |
| pktMcast | input | 1 | Packet is multicast |
| pktDest | input | NUM_PORTS | Destination output bitmap |
| pktAccept | output | 1 | Packet accepted |
| pktDrop | output | 1 | Packet discarded as a violation |
| statusViol | output | 1 | Sticky violation status |
| violPorts | output | NUM_PORTS | Sticky per-output violation bits |
| irq | output | 1 | Violation interrupt |

## Verification
A wrong grant age appears at the ports the first time a packet probes that output. The drop decision then flips in that same combinational cycle: accepted where a drop is due, or the reverse. It is off by one exactly when the probe lands at age n-1 or age n. For this reason, the bench sweeps every window value against every age from 0 past saturation, for both grant kinds and both packet kinds. A corrupt sticky bit shows one edge after the packet cycle, in `statusViol`, `violPorts` or `irq`, and it persists until the matching clear.

// File: rtl/fvg_pkg.sv
package fvg_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic tick;       // packet-cycle boundary
    logic setStatus;  // a packet was dropped this cycle
    logic clrStatus;  // host write-one-to-clear of the status bit
  } fvgStrobe_t;
endpackage

// File: rtl/fvg_age_ctr.sv
module fvg_age_ctr #(
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  input  logic             tick,
  input  logic [WIN_W-1:0] window,
  output logic             recent
);
  localparam logic [WIN_W-1:0] AGE_MAX = {WIN_W{1'b1}};

  logic [WIN_W-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age <= AGE_MAX;
    end else if (grant) begin
      age <= '0;
    end else if (tick && (age != AGE_MAX)) begin
      age <= age + 1'b1;
    end
  end

  assign recent = (age < window);
endmodule

// File: rtl/fvg_datapath.sv
module fvg_datapath
  import fvg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int WIN_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  fvgStrobe_t           strobes,
  input  logic [NUM_PORTS-1:0] oqGrant,
  input  logic [NUM_PORTS-1:0] memGrant,
  input  logic [WIN_W-1:0]     window,
  input  logic [NUM_PORTS-1:0] violSet,
  input  logic [NUM_PORTS-1:0] violClr,
  output logic [NUM_PORTS-1:0] oqRecent,
  output logic [NUM_PORTS-1:0] memRecent,
  output logic                 statusViol,
  output logic [NUM_PORTS-1:0] violPorts
);
  // One age counter per output and grant kind
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    fvg_age_ctr #(.WIN_W(WIN_W)) u_oqAge (
      .clk    (clk),
      .rst_n  (rst_n),
      .grant  (oqGrant[p]),
      .tick   (strobes.tick),
      .window (window),
      .recent (oqRecent[p])
    );
    fvg_age_ctr #(.WIN_W(WIN_W)) u_memAge (
      .clk    (clk),
      .rst_n  (rst_n),
      .grant  (memGrant[p]),
      .tick   (strobes.tick),
      .window (window),
      .recent (memRecent[p])
    );

    // Sticky violation bit, set has priority over clear
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        violPorts[p] <= 1'b0;
      end else if (violSet[p]) begin
        violPorts[p] <= 1'b1;
      end else if (violClr[p]) begin
        violPorts[p] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statusViol <= 1'b0;
    end else if (strobes.setStatus) begin
      statusViol <= 1'b1;
    end else if (strobes.clrStatus) begin
      statusViol <= 1'b0;
    end
  end
endmodule

// File: rtl/fvg_control.sv
module fvg_control
  import fvg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int WIN_W     = 4
) (
  input  logic                 cfgEnable,
  input  logic [WIN_W-1:0]     cfgWindow,
  input  logic                 clrStatus,
  input  logic                 cycleStrobe,
  input  logic                 pktValid,
  input  logic                 pktMcast,
  input  logic [NUM_PORTS-1:0] pktDest,
  input  logic [NUM_PORTS-1:0] oqRecent,
  input  logic [NUM_PORTS-1:0] memRecent,
  output logic [WIN_W-1:0]     window,
  output logic [NUM_PORTS-1:0] violSet,
  output fvgStrobe_t           strobes,
  output logic                 pktAccept,
  output logic                 pktDrop
);
  logic [NUM_PORTS-1:0] okPorts;
  logic [NUM_PORTS-1:0] badPorts;
  logic                 violation;

  // A zero window is treated as the smallest legal window
  assign window = (cfgWindow == '0) ? WIN_W'(1) : cfgWindow;

  // Multicast honours memory grants only
  assign okPorts   = pktMcast ? memRecent : (oqRecent | memRecent);
  assign badPorts  = pktDest & ~okPorts;
  assign violation = pktValid && cfgEnable && (badPorts != '0);

  assign pktDrop   = violation;
  assign pktAccept = pktValid && !violation;
  assign violSet   = violation ? badPorts : '0;

  always_comb begin
    strobes           = '0;
    strobes.tick      = cycleStrobe;
    strobes.setStatus = violation;
    strobes.clrStatus = clrStatus;
  end
endmodule

// File: rtl/flow_violation_guard.sv
module flow_violation_guard
  import fvg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int WIN_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfgEnable,
  input  logic [WIN_W-1:0]     cfgWindow,
  input  logic                 intMask,
  input  logic                 clrStatus,
  input  logic [NUM_PORTS-1:0] clrViol,
  input  logic                 cycleStrobe,
  input  logic [NUM_PORTS-1:0] oqGrant,
  input  logic [NUM_PORTS-1:0] memGrant,
  input  logic                 pktValid,
  input  logic                 pktMcast,
  input  logic [NUM_PORTS-1:0] pktDest,
  output logic                 pktAccept,
  output logic                 pktDrop,
  output logic                 statusViol,
  output logic [NUM_PORTS-1:0] violPorts,
  output logic                 irq
);
  fvgStrobe_t           strobes;
  logic [WIN_W-1:0]     window;
  logic [NUM_PORTS-1:0] violSet;
  logic [NUM_PORTS-1:0] oqRecent;
  logic [NUM_PORTS-1:0] memRecent;

  fvg_control #(.NUM_PORTS(NUM_PORTS), .WIN_W(WIN_W)) u_ctrl (
    .cfgEnable   (cfgEnable),
    .cfgWindow   (cfgWindow),
    .clrStatus   (clrStatus),
    .cycleStrobe (cycleStrobe),
    .pktValid    (pktValid),
    .pktMcast    (pktMcast),
    .pktDest     (pktDest),
    .oqRecent    (oqRecent),
    .memRecent   (memRecent),
    .window      (window),
    .violSet     (violSet),
    .strobes     (strobes),
    .pktAccept   (pktAccept),
    .pktDrop     (pktDrop)
  );

  fvg_datapath #(.NUM_PORTS(NUM_PORTS), .WIN_W(WIN_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .oqGrant    (oqGrant),
    .memGrant   (memGrant),
    .window     (window),
    .violSet    (violSet),
    .violClr    (clrViol),
    .oqRecent   (oqRecent),
    .memRecent  (memRecent),
    .statusViol (statusViol),
    .violPorts  (violPorts)
  );

  assign irq = statusViol && !intMask;
endmodule

// File: rtl/fvg_checker.sv
module fvg_checker #(
  parameter int NUM_PORTS = 4,
  parameter int WIN_W     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfgEnable,
  input logic                 intMask,
  input logic                 clrStatus,
  input logic [NUM_PORTS-1:0] clrViol,
  input logic [NUM_PORTS-1:0] memGrant,
  input logic                 pktValid,
  input logic [NUM_PORTS-1:0] pktDest,
  input logic                 pktAccept,
  input logic                 pktDrop,
  input logic                 statusViol,
  input logic [NUM_PORTS-1:0] violPorts,
  input logic                 irq
);
  AST_DROP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    pktDrop |-> (cfgEnable && pktValid)); // R1

  AST_FRESH_MEM_GRANT_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (pktValid && (pktDest != '0) && ((pktDest & ~$past(memGrant)) == '0)) |-> pktAccept); // R2

  AST_ACCEPT_DROP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pktAccept && pktDrop)); // R4

  AST_DROP_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    pktDrop |=> statusViol); // R6

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (statusViol && !clrStatus) |=> statusViol); // R6

  AST_DROP_MARKS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    pktDrop |=> (violPorts != '0)); // R7

  AST_VIOL_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(violPorts) & ~$past(clrViol) & ~violPorts) == '0)); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (statusViol && !intMask)); // R8
endmodule

bind flow_violation_guard fvg_checker #(.NUM_PORTS(NUM_PORTS), .WIN_W(WIN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfgEnable  (cfgEnable),
  .intMask    (intMask),
  .clrStatus  (clrStatus),
  .clrViol    (clrViol),
  .memGrant   (memGrant),
  .pktValid   (pktValid),
  .pktDest    (pktDest),
  .pktAccept  (pktAccept),
  .pktDrop    (pktDrop),
  .statusViol (statusViol),
  .violPorts  (violPorts),
  .irq        (irq)
);

// File: tb/tb_flow_violation_guard.sv
`timescale 1ns/100ps
module tb_flow_violation_guard;
  localparam int P = 4;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgEnable = 1'b0;
  logic [W-1:0] cfgWindow = '0;
  logic intMask = 1'b0;
  logic clrStatus = 1'b0;
  logic [P-1:0] clrViol = '0;
  logic cycleStrobe = 1'b0;
  logic [P-1:0] oqGrant = '0;
  logic [P-1:0] memGrant = '0;
  logic pktValid = 1'b0;
  logic pktMcast = 1'b0;
  logic [P-1:0] pktDest = '0;
  logic pktAccept, pktDrop, statusViol, irq;
  logic [P-1:0] violPorts;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  flow_violation_guard #(.NUM_PORTS(P), .WIN_W(W)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cycleStrobe = 1'b1;
    end
    @(negedge clk); cycleStrobe = 1'b0;
  endtask

  task automatic clearAll();
    @(negedge clk); clrStatus = 1'b1; clrViol = '1;
    @(negedge clk); clrStatus = 1'b0; clrViol = '0;
  endtask

  // Present a packet at the next negedge; combinational result sampled 1 ns later
  task automatic probe(input logic mc, input logic [P-1:0] dest, input string req, input int expDrop);
    @(negedge clk); pktValid = 1'b1; pktMcast = mc; pktDest = dest;
    #1;
    chk(req, int'(pktDrop), expDrop);
    chk(req, int'(pktAccept), 1 - expDrop);
    @(negedge clk); pktValid = 1'b0; pktDest = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R6 reset status", int'(statusViol), 0);
    chk("R7 reset viol", int'(violPorts), 0);
    chk("R8 reset irq", int'(irq), 0);

    // R5 reset ages are saturated: enabled unicast to any port drops
    cfgEnable = 1'b1; cfgWindow = 4'd15;
    probe(1'b0, 4'b0100, "R5 reset age saturated", 1);
    clearAll();

    // Sweep: every window, both grant kinds, both packet kinds, ages 0..16
    for (int n = 1; n <= 15; n++) begin
      for (int g = 0; g < 2; g++) begin
        for (int mc = 0; mc < 2; mc++) begin
          int p;
          p = (n + g + mc) % P;
          cfgWindow = W'(n);
          strobes(16);
          @(negedge clk);
          if (g == 0) oqGrant[p] = 1'b1; else memGrant[p] = 1'b1;
          @(negedge clk); oqGrant = '0; memGrant = '0;
          for (int k = 0; k <= 16; k++) begin
            int expOk;
            expOk = ((k < n) && (mc == 0 || g == 1)) ? 1 : 0;
            probe(mc[0], P'(1 << p), mc ? "R3 multicast sweep" : "R2 unicast sweep", 1 - expOk);
            strobes(1);
          end
        end
      end
    end
    clearAll();

    // R1 enable off: stale history never drops
    cfgEnable = 1'b0; strobes(16);
    probe(1'b0, 4'b1111, "R1 disabled unicast", 0);
    probe(1'b1, 4'b1111, "R1 disabled multicast", 0);
    @(negedge clk); #1;
    chk("R1 no status when disabled", int'(statusViol), 0);
    cfgEnable = 1'b1;

    // R4 empty destination is accepted
    probe(1'b0, 4'b0000, "R4 empty dest", 0);

    // R4 grant in the same cycle as the packet is not yet seen
    @(negedge clk); pktValid = 1'b1; pktMcast = 1'b0; pktDest = 4'b0010; memGrant = 4'b0010;
    #1; chk("R4 same-cycle grant unseen", int'(pktDrop), 1);
    @(negedge clk); pktValid = 1'b0; pktDest = '0; memGrant = '0;
    #1;
    chk("R6 status set after drop", int'(statusViol), 1);
    chk("R7 viol bit of dest", int'(violPorts), 2);
    chk("R8 irq unmasked", int'(irq), 1);
    intMask = 1'b1; #0.5;
    chk("R8 irq masked", int'(irq), 0);
    intMask = 1'b0;
    // the grant seen at the edge made port1 fresh
    probe(1'b1, 4'b0010, "R4 grant visible next cycle", 0);
    clearAll(); #1;
    chk("R6 status cleared", int'(statusViol), 0);
    chk("R7 viol cleared", int'(violPorts), 0);

    // R5 grant beats strobe in the same cycle
    cfgWindow = 4'd1; strobes(16);
    @(negedge clk); cycleStrobe = 1'b1; oqGrant = 4'b1000;
    @(negedge clk); cycleStrobe = 1'b0; oqGrant = '0;
    probe(1'b0, 4'b1000, "R5 grant wins over strobe", 0);

    // R9 window 0 behaves as 1
    cfgWindow = 4'd0; strobes(16);
    @(negedge clk); memGrant = 4'b0001;
    @(negedge clk); memGrant = '0;
    probe(1'b1, 4'b0001, "R9 window0 age0 passes", 0);
    strobes(1);
    probe(1'b1, 4'b0001, "R9 window0 age1 drops", 1);
    clearAll();

    // R3/R7 multicast with several destinations: only the stale ones are marked
    cfgWindow = 4'd4; strobes(16);
    @(negedge clk); memGrant = 4'b0010; oqGrant = 4'b0101;
    @(negedge clk); memGrant = '0; oqGrant = '0;
    probe(1'b1, 4'b0111, "R3 multicast mixed grants", 1);
    #1; chk("R7 stale mcast ports marked", int'(violPorts), 5);
    probe(1'b0, 4'b0111, "R2 unicast accepts either kind", 0);

    // R7 per-bit clear and set-wins-clear
    @(negedge clk); clrViol = 4'b0001;
    @(negedge clk); clrViol = '0; #1;
    chk("R7 per-bit clear", int'(violPorts), 4);
    @(negedge clk); clrViol = 4'b1000; clrStatus = 1'b1;
    pktValid = 1'b1; pktMcast = 1'b0; pktDest = 4'b1000;
    @(negedge clk); clrViol = '0; clrStatus = 1'b0; pktValid = 1'b0; pktDest = '0; #1;
    chk("R7 set wins clear", int'(violPorts), 12);
    chk("R6 set wins clear", int'(statusViol), 1);

    finishRun();
  end
endmodule